// File: doc/BRIEF.md
# Set-Associative Data Cache

This block is a data cache placed between a processor load/store port and a word-wide backing memory. Every 32-bit byte address is cut into three fields: a block offset of log2(BLOCK_BYTES) bits at the bottom, a set index of log2(CAPACITY_BYTES / (BLOCK_BYTES * WAYS)) bits above it, and a tag formed from the remaining upper bits. All ways of the indexed set are compared at once. A read hit completes in the cycle it is presented. A miss brings in the whole block, one 32-bit word per memory handshake.

The parameter WRITE_BACK fixes the write policy when the block is built. With WRITE_BACK=1, a write that hits changes only the cache and marks the line dirty. A write that misses first allocates the block and then writes it. A dirty victim is copied back in full before its replacement is fetched. With WRITE_BACK=0, every write goes to memory as one word write. A write hit also updates the cached copy, and a write miss leaves the cache untouched. Each set tracks least-recently-used order, and that order chooses the victim when the set is full. The processor sees a single ready signal. It holds its request stable until ready is high, and the access completes on that clock edge.

Top module: `set_assoc_cache`

## Requirements
- R1: Address bit fields are offset = addr[OFF_W-1:0] with word select addr[OFF_W-1:2], index = addr[OFF_W+IDX_W-1:OFF_W] and tag = the bits above that. A read always returns the most recently written value of the addressed word, including when several blocks share an index, and at most one way of a set matches a tag.
- R2: After reset no line is valid, so the first access to any block misses. While no request is pending, ready_o and mem_req_o are low.
- R3: A read hit raises ready_o in the same cycle the request is presented, with the selected word on rdata_o, and makes no memory request.
- R4: A read miss fetches all BLOCK_BYTES/4 words of the block, one memory read per word. The reads go from the block base in ascending word order, and the request then completes with the fetched data.
- R5: With WRITE_BACK=1, a write hit completes in the cycle it is presented. It updates only the cached word and issues no memory access.
- R6: With WRITE_BACK=1, a write miss reads the whole block from memory, performs no memory write, and then stores the word into the newly allocated line.
- R7: With WRITE_BACK=1, a dirty victim is written back word by word in ascending order at its own block address, and this finishes before the first refill read. A clean victim is replaced with no memory write.
- R8: With WRITE_BACK=0, a write hit issues exactly one memory write of that word to its address, and a later read of that word hits with the new value.
- R9: With WRITE_BACK=0, a write miss issues exactly one memory write and no memory read. No line is allocated, so a following read of that block misses.
- R10: With WAYS>1, a set fill uses an invalid way first. Once all ways are valid, it replaces the least recently used way, so the most recently accessed way survives.
- R11: ready_o stays low for the whole of any eviction, refill or write-through memory transfer. The processor keeps req_i, we_i and addr_i unchanged until ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address, word aligned |
| wdata_i | input | 32 | Store data |
| ready_o | output | 1 | Access completes on this edge |
| rdata_o | output | 32 | Load data, valid with ready_o on a load |
| mem_req_o | output | 1 | Memory word transfer request, held until acknowledged |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Memory byte address of the word |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory transfer completes this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ack_i |

## Verification
Two functions can meet on one miss: writing back a dirty victim and refilling its set. Both happen within one request and share the memory port. The bench provokes this by dirtying a line, making it the least recently used way, and then reading a third block with the same index. It then checks the logged memory operations: four writes in ascending order at the victim's address must come first, followed by four reads at the new block. The written-back data must also reach the backing memory. A write-through write hit is checked the same way: a single memory write must happen in the cycle that updates the cached word, and the next read must hit with the new value.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU
  } cache_state_e;
endpackage

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int WAYS = 2,
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);

  if (WAYS == 1) begin : g_direct
    logic unused_lru;
    assign unused_lru = ^{clk_i, rst_ni, idx_i, valid_i, touch_i, touch_way_i};
    assign victim_o = '0;
  end else begin : g_assoc
    // age 0 = most recent, WAYS-1 = least recent
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            age_q[s][w] <= WAY_W'(w);
      end else if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way_i)
            age_q[idx_i][w] <= '0;
          else if (age_q[idx_i][w] < age_q[idx_i][touch_way_i])
            age_q[idx_i][w] <= age_q[idx_i][w] + 1'b1;
        end
      end
    end

    always_comb begin
      victim_o = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[idx_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
      for (int w = WAYS - 1; w >= 0; w--)
        if (!valid_i[w]) victim_o = WAY_W'(w);
    end

    AST_MRU_NOT_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (touch_i && &valid_i) |=>
        (!($stable(idx_i) && &valid_i) || victim_o != $past(touch_way_i))) // R10
      else $error("AST_MRU_NOT_VICTIM");
  end

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int WAYS = 2,
  parameter int SETS = 8,
  parameter int TAG_W = 25,
  parameter bit WRITE_BACK = 1'b1,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAYS-1:0]  valid_o,
  input  logic [WAY_W-1:0] sel_way_i,
  output logic [TAG_W-1:0] sel_tag_o,
  output logic             sel_dirty_o,
  input  logic             alloc_i,
  input  logic [WAY_W-1:0] alloc_way_i,
  input  logic             set_dirty_i,
  input  logic [WAY_W-1:0] dirty_way_i
);

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  hit_vec;

  always_ff @(posedge clk_i) begin
    if (alloc_i) tag_q[idx_i][alloc_way_i] <= tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (alloc_i) begin
      valid_q[idx_i][alloc_way_i] <= 1'b1;
    end
  end

  if (WRITE_BACK) begin : g_dirty
    logic [WAYS-1:0] dirty_q [SETS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) dirty_q[s] <= '0;
      end else if (alloc_i) begin
        dirty_q[idx_i][alloc_way_i] <= 1'b0;
      end else if (set_dirty_i) begin
        dirty_q[idx_i][dirty_way_i] <= 1'b1;
      end
    end
    assign sel_dirty_o = dirty_q[idx_i][sel_way_i] & valid_q[idx_i][sel_way_i];
  end else begin : g_clean
    logic unused_dirty;
    assign unused_dirty = ^{set_dirty_i, dirty_way_i};
    assign sel_dirty_o = 1'b0;
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o     = |hit_vec;
  assign valid_o   = valid_q[idx_i];
  assign sel_tag_o = tag_q[idx_i][sel_way_i];

  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)) // R1
    else $error("AST_SINGLE_MATCH");

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int WAYS = 2,
  parameter int SETS = 8,
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [31:0]       wr_data_i,
  input  logic [WAY_W-1:0]  ra_way_i,
  input  logic [WORD_W-1:0] ra_word_i,
  output logic [31:0]       ra_data_o,
  input  logic [WAY_W-1:0]  rb_way_i,
  input  logic [WORD_W-1:0] rb_word_i,
  output logic [31:0]       rb_data_o
);

  logic [31:0] data_q [WAYS][SETS][WORDS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_way_i][idx_i][wr_word_i] <= wr_data_i;
  end

  assign ra_data_o = data_q[ra_way_i][idx_i][ra_word_i];
  assign rb_data_o = data_q[rb_way_i][idx_i][rb_word_i];

endmodule

// File: rtl/set_assoc_cache.sv
module set_assoc_cache
  import cache_pkg::*;
#(
  parameter int CAPACITY_BYTES = 256,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic [31:0] rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i
);

  localparam int WORDS  = BLOCK_BYTES / 4;
  localparam int SETS   = CAPACITY_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WORD_W = $clog2(WORDS);
  localparam int TAG_W  = 32 - IDX_W - OFF_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WORD_W-1:0] a_word;
  logic              unused_lsb;

  assign a_tag      = addr_i[31 -: TAG_W];
  assign a_idx      = addr_i[OFF_W +: IDX_W];
  assign a_word     = addr_i[2 +: WORD_W];
  assign unused_lsb = ^addr_i[1:0];

  cache_state_e      state_q, state_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic [WAY_W-1:0]  vict_q, vict_d;

  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAYS-1:0]   set_valid;
  logic [WAY_W-1:0]  lru_victim;
  logic [WAY_W-1:0]  sel_way;
  logic [TAG_W-1:0]  sel_tag;
  logic              sel_dirty;
  logic [31:0]       evict_word;

  logic              wt_store;
  logic              wb_store_hit;
  logic              alloc;
  logic              touch;
  logic              dwr_en;
  logic [WAY_W-1:0]  dwr_way;
  logic [WORD_W-1:0] dwr_word;
  logic [31:0]       dwr_data;

  assign wt_store     = !WRITE_BACK && we_i;
  assign wb_store_hit = WRITE_BACK && state_q == ST_IDLE && req_i && we_i && hit;
  assign sel_way      = (state_q == ST_IDLE) ? lru_victim : vict_q;

  assign ready_o = (state_q == ST_IDLE && req_i && hit && !wt_store) ||
                   (state_q == ST_WTHRU && mem_ack_i);
  assign touch   = ready_o && hit;
  assign alloc   = state_q == ST_FILL && mem_ack_i && beat_q == LAST_BEAT;

  always_comb begin
    dwr_en   = 1'b0;
    dwr_way  = hit_way;
    dwr_word = a_word;
    dwr_data = wdata_i;
    if (state_q == ST_FILL && mem_ack_i) begin
      dwr_en   = 1'b1;
      dwr_way  = vict_q;
      dwr_word = beat_q;
      dwr_data = mem_rdata_i;
    end else if (wb_store_hit || (state_q == ST_WTHRU && mem_ack_i && hit)) begin
      dwr_en = 1'b1;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {addr_i[31:2], 2'b00};
    mem_wdata_o = wdata_i;
    unique case (state_q)
      ST_EVICT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {sel_tag, a_idx, beat_q, 2'b00};
        mem_wdata_o = evict_word;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {a_tag, a_idx, beat_q, 2'b00};
      end
      ST_WTHRU: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    vict_d  = vict_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && !ready_o) begin
          beat_d = '0;
          vict_d = lru_victim;
          if (wt_store)       state_d = ST_WTHRU;
          else if (sel_dirty) state_d = ST_EVICT;
          else                state_d = ST_FILL;
        end
      end
      ST_EVICT: begin
        if (mem_ack_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_IDLE;
        end
      end
      ST_WTHRU: begin
        if (mem_ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      vict_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      vict_q  <= vict_d;
    end
  end

  cache_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
  ) i_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (a_idx),
    .tag_i       (a_tag),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .valid_o     (set_valid),
    .sel_way_i   (sel_way),
    .sel_tag_o   (sel_tag),
    .sel_dirty_o (sel_dirty),
    .alloc_i     (alloc),
    .alloc_way_i (vict_q),
    .set_dirty_i (wb_store_hit),
    .dirty_way_i (hit_way)
  );

  cache_lru #(.WAYS(WAYS), .SETS(SETS)) i_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (a_idx),
    .valid_i     (set_valid),
    .touch_i     (touch),
    .touch_way_i (hit_way),
    .victim_o    (lru_victim)
  );

  cache_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)) i_data (
    .clk_i     (clk_i),
    .idx_i     (a_idx),
    .wr_en_i   (dwr_en),
    .wr_way_i  (dwr_way),
    .wr_word_i (dwr_word),
    .wr_data_i (dwr_data),
    .ra_way_i  (hit_way),
    .ra_word_i (a_word),
    .ra_data_o (rdata_o),
    .rb_way_i  (vict_q),
    .rb_word_i (beat_q),
    .rb_data_o (evict_word)
  );

  AST_STALL_DURING_LINE_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EVICT || state_q == ST_FILL) |-> !ready_o) // R11
    else $error("AST_STALL_DURING_LINE_XFER");

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |=> (req_i && $stable(addr_i) && $stable(we_i))) // R11
    else $error("AST_REQ_HELD");

  AST_EVICT_DONE_BEFORE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && $past(state_q) == ST_EVICT) |->
      $past(mem_ack_i && beat_q == LAST_BEAT)) // R7
    else $error("AST_EVICT_DONE_BEFORE_FILL");

  AST_FILL_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && $past(state_q) == ST_FILL && $past(mem_ack_i)) |->
      beat_q == $past(beat_q) + 1'b1) // R4
    else $error("AST_FILL_ASCENDS");

endmodule

// File: tb/test_set_assoc_cache.sv
`timescale 1ns/1ps
module test_set_assoc_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        we, a_req, b_req;
  logic [31:0] addr, wdata;
  logic        a_rdy, b_rdy, a_mreq, b_mreq, a_mwe, b_mwe;
  logic [31:0] a_rdata, b_rdata, a_maddr, b_maddr, a_mwdata, b_mwdata;
  logic        a_ack, b_ack;
  logic [31:0] mem_a [1024];
  logic [31:0] mem_b [1024];
  logic [31:0] ref_a [1024];
  logic [31:0] ref_b [1024];
  int a_nrd, a_nwr, a_nops, b_nrd, b_nwr, b_nops;
  bit     a_lwe [256];
  int     a_ladr [256];
  bit     b_lwe [256];
  int     b_ladr [256];
  int n_chk, n_fail;

  set_assoc_cache #(.WRITE_BACK(1'b1)) i_set_assoc_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(a_req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(a_rdy), .rdata_o(a_rdata), .mem_req_o(a_mreq),
    .mem_we_o(a_mwe), .mem_addr_o(a_maddr), .mem_wdata_o(a_mwdata),
    .mem_ack_i(a_ack), .mem_rdata_i(mem_a[a_maddr[11:2]]));

  set_assoc_cache #(.WRITE_BACK(1'b0)) i_set_assoc_cache_wt (
    .clk_i(clk), .rst_ni(rst_n), .req_i(b_req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(b_rdy), .rdata_o(b_rdata), .mem_req_o(b_mreq),
    .mem_we_o(b_mwe), .mem_addr_o(b_maddr), .mem_wdata_o(b_mwdata),
    .mem_ack_i(b_ack), .mem_rdata_i(mem_b[b_maddr[11:2]]));

  function automatic logic [31:0] init_val(int i);
    return 32'h1000_0000 + i * 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ack <= 1'b0; b_ack <= 1'b0;
    end else begin
      a_ack <= a_mreq && !a_ack;
      b_ack <= b_mreq && !b_ack;
      if (a_mreq && a_ack) begin
        if (a_mwe) begin mem_a[a_maddr[11:2]] <= a_mwdata; a_nwr <= a_nwr + 1; end
        else a_nrd <= a_nrd + 1;
        a_lwe[a_nops % 256] <= a_mwe;
        a_ladr[a_nops % 256] <= int'(a_maddr);
        a_nops <= a_nops + 1;
      end
      if (b_mreq && b_ack) begin
        if (b_mwe) begin mem_b[b_maddr[11:2]] <= b_mwdata; b_nwr <= b_nwr + 1; end
        else b_nrd <= b_nrd + 1;
        b_lwe[b_nops % 256] <= b_mwe;
        b_ladr[b_nops % 256] <= int'(b_maddr);
        b_nops <= b_nops + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit wt, input bit w, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] rd, output int stalls);
    we = w; addr = a; wdata = d;
    if (wt) b_req = 1'b1; else a_req = 1'b1;
    stalls = 0;
    #1;
    while (!(wt ? b_rdy : a_rdy)) begin
      stalls++;
      if (stalls > 100) begin
        chk(1'b0, "R11", "access timeout", 32'(stalls), 32'd100);
        break;
      end
      @(negedge clk); #1;
    end
    rd = wt ? b_rdata : a_rdata;
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
  endtask

  function automatic bit ops_match(bit wt, int start, int cnt, bit w, int base);
    for (int k = 0; k < cnt; k++) begin
      int j = (start + k) % 256;
      if (wt) begin
        if (b_lwe[j] != w || b_ladr[j] != base + 4 * k) return 1'b0;
      end else begin
        if (a_lwe[j] != w || a_ladr[j] != base + 4 * k) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st, r0, w0, o0;
    bit ok;
    n_chk = 0; n_fail = 0;
    a_nrd = 0; a_nwr = 0; a_nops = 0; b_nrd = 0; b_nwr = 0; b_nops = 0;
    a_req = 0; b_req = 0; we = 0; addr = 0; wdata = 0;
    for (int i = 0; i < 1024; i++) begin
      mem_a[i] = init_val(i); mem_b[i] = init_val(i);
      ref_a[i] = init_val(i); ref_b[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_rdy && !b_rdy, "R2", "ready idle after reset", {31'd0, a_rdy | b_rdy}, 0);
    chk(!a_mreq && !b_mreq, "R2", "no memory request after reset", {31'd0, a_mreq | b_mreq}, 0);

    // R4 / R2: cold read miss fills block in ascending order
    r0 = a_nrd; o0 = a_nops;
    access(0, 0, 32'h000, 0, rd, st);
    chk(rd == ref_a[0], "R4", "cold miss data", rd, ref_a[0]);
    chk(a_nrd - r0 == 4, "R2", "cold miss reads", 32'(a_nrd - r0), 4);
    chk(ops_match(0, o0, 4, 0, 0), "R4", "fill order", 32'(a_ladr[o0 % 256]), 0);
    chk(st >= 8, "R11", "stall covers fill", 32'(st), 8);

    // R3: hit in same cycle
    o0 = a_nops;
    access(0, 0, 32'h00C, 0, rd, st);
    chk(st == 0, "R3", "hit latency", 32'(st), 0);
    chk(a_nops == o0, "R3", "hit memory ops", 32'(a_nops - o0), 0);
    chk(rd == ref_a[3], "R3", "hit data", rd, ref_a[3]);

    // R1: fill whole capacity, then everything resident
    for (int a = 0; a < 256; a += 4) begin
      access(0, 0, 32'(a), 0, rd, st);
      chk(rd == ref_a[a / 4], "R1", "sweep read", rd, ref_a[a / 4]);
    end
    o0 = a_nops;
    for (int a = 0; a < 256; a += 4) access(0, 0, 32'(a), 0, rd, st);
    chk(a_nops == o0, "R1", "capacity resident", 32'(a_nops - o0), 0);

    // R5: write-back write hit
    o0 = a_nops;
    access(0, 1, 32'h010, 32'hDEAD_0010, rd, st);
    ref_a[4] = 32'hDEAD_0010;
    chk(st == 0 && a_nops == o0, "R5", "write hit quiet", 32'(a_nops - o0 + st), 0);
    access(0, 0, 32'h010, 0, rd, st);
    chk(rd == 32'hDEAD_0010, "R5", "write hit readback", rd, 32'hDEAD_0010);
    chk(mem_a[4] == init_val(4), "R5", "memory untouched", mem_a[4], init_val(4));

    // R10 / R7 clean victim
    access(0, 0, 32'h000, 0, rd, st);
    r0 = a_nrd; w0 = a_nwr;
    access(0, 0, 32'h100, 0, rd, st);
    chk(a_nwr == w0 && a_nrd - r0 == 4, "R7", "clean victim no writeback", 32'(a_nwr - w0), 0);
    chk(rd == ref_a[64], "R4", "conflict miss data", rd, ref_a[64]);
    access(0, 0, 32'h000, 0, rd, st);
    chk(st == 0, "R10", "recent way kept", 32'(st), 0);
    r0 = a_nrd;
    access(0, 0, 32'h080, 0, rd, st);
    chk(a_nrd - r0 == 4, "R10", "lru way replaced", 32'(a_nrd - r0), 4);

    // R7 dirty victim: writeback then refill
    access(0, 0, 32'h090, 0, rd, st);
    o0 = a_nops;
    access(0, 0, 32'h110, 0, rd, st);
    chk(a_nops - o0 == 8, "R7", "evict+fill op count", 32'(a_nops - o0), 8);
    chk(ops_match(0, o0, 4, 1, 32'h010), "R7", "writeback order", 32'(a_ladr[o0 % 256]), 32'h010);
    chk(ops_match(0, o0 + 4, 4, 0, 32'h110), "R7", "refill after writeback",
        32'(a_ladr[(o0 + 4) % 256]), 32'h110);
    chk(mem_a[4] == 32'hDEAD_0010, "R7", "dirty data reached memory", mem_a[4], 32'hDEAD_0010);
    chk(rd == ref_a[68], "R7", "refill data", rd, ref_a[68]);

    // R6 write-allocate
    r0 = a_nrd; w0 = a_nwr;
    access(0, 1, 32'h300, 32'hBEEF_0300, rd, st);
    ref_a[192] = 32'hBEEF_0300;
    chk(a_nrd - r0 == 4 && a_nwr == w0, "R6", "write miss allocates", 32'(a_nrd - r0), 4);
    access(0, 0, 32'h300, 0, rd, st);
    chk(st == 0 && rd == 32'hBEEF_0300, "R6", "allocated line holds store", rd, 32'hBEEF_0300);
    chk(mem_a[192] == init_val(192), "R6", "memory not yet written", mem_a[192], init_val(192));

    // R1 stress over 4 KB
    for (int a = 0; a < 4096; a += 4) begin
      access(0, 1, 32'(a), 32'(a) * 32'h0101_0101 ^ 32'h5A5A_00C3, rd, st);
      ref_a[a / 4] = 32'(a) * 32'h0101_0101 ^ 32'h5A5A_00C3;
    end
    ok = 1'b1;
    for (int a = 0; a < 4096; a += 4) begin
      access(0, 0, 32'(a), 0, rd, st);
      if (rd != ref_a[a / 4]) begin
        ok = 1'b0;
        chk(1'b0, "R1", "stress read", rd, ref_a[a / 4]);
      end
    end
    chk(ok, "R1", "stress all words", 0, 0);

    // R8 write-through hit
    access(1, 0, 32'h020, 0, rd, st);
    r0 = b_nrd; w0 = b_nwr; o0 = b_nops;
    access(1, 1, 32'h020, 32'hCAFE_0020, rd, st);
    ref_b[8] = 32'hCAFE_0020;
    chk(b_nwr - w0 == 1 && b_nrd == r0, "R8", "single memory write", 32'(b_nwr - w0), 1);
    chk(ops_match(1, o0, 1, 1, 32'h020), "R8", "write address", 32'(b_ladr[o0 % 256]), 32'h020);
    chk(mem_b[8] == 32'hCAFE_0020, "R8", "memory updated", mem_b[8], 32'hCAFE_0020);
    chk(st >= 1, "R11", "stall on write-through", 32'(st), 1);
    access(1, 0, 32'h020, 0, rd, st);
    chk(st == 0 && rd == 32'hCAFE_0020, "R8", "cache updated", rd, 32'hCAFE_0020);

    // R9 write-around
    r0 = b_nrd; w0 = b_nwr;
    access(1, 1, 32'h400, 32'hF00D_0400, rd, st);
    ref_b[256] = 32'hF00D_0400;
    chk(b_nwr - w0 == 1 && b_nrd == r0, "R9", "write miss memory only", 32'(b_nrd - r0), 0);
    chk(mem_b[256] == 32'hF00D_0400, "R9", "memory holds store", mem_b[256], 32'hF00D_0400);
    r0 = b_nrd;
    access(1, 0, 32'h400, 0, rd, st);
    chk(b_nrd - r0 == 4, "R9", "no allocation", 32'(b_nrd - r0), 4);
    chk(rd == 32'hF00D_0400, "R9", "read after write-around", rd, 32'hF00D_0400);

    // R8 / R9 sweep
    for (int a = 0; a < 1024; a += 4) begin
      access(1, 1, 32'(a), ~(32'(a) * 32'h0003_0007), rd, st);
      ref_b[a / 4] = ~(32'(a) * 32'h0003_0007);
    end
    ok = 1'b1;
    for (int a = 0; a < 1024; a += 4) begin
      access(1, 0, 32'(a), 0, rd, st);
      if (rd != ref_b[a / 4] || mem_b[a / 4] != ref_b[a / 4]) begin
        ok = 1'b0;
        chk(1'b0, "R8", "write-through sweep", rd, ref_b[a / 4]);
      end
    end
    chk(ok, "R9", "write-through sweep all", 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule